// File: doc/BRIEF.md
# March Test Control Sequencer

This block steps an externally steered memory self-test datapath through a fixed six-element march test. It holds no address and no data: each clock it emits an operation-valid flag, an address direction, an address hold/advance bit, a data polarity and a read/write select. The datapath owns the address counter, the write data, the comparator and the fail counter. The datapath answers with a terminal pulse on the advancing operation at the last address of a pass.

The six elements run in this order: ascending write zeros; ascending read zeros then write ones; ascending read ones then write zeros; descending read zeros then write ones; descending read ones then write zeros; descending read zeros. In an element with two operations, the address holds on the read and moves on the write. The sequencer also emits two load pulses. One loads the bottom address when a run is accepted. The other loads the top address as the third element ends, so that the descending elements begin at the maximum address. A done flag marks completion and stays high until the next start.

Top module: `march_seq`

## Requirements
- R1: After reset, and whenever no run is active, op_valid_o, wr_en_o, addr_adv_o, seed_high_o and done_o are 0.
- R2: start_i sampled high with no run active raises seed_low_o in that same cycle. The first operation of element 1 appears in the next cycle. start_i sampled high during a run has no effect.
- R3: Per element, with addr_dir_o 0 = ascending and 1 = descending, wr_en_o 1 = write and 0 = read, and data_pol_o 1 = all ones and 0 = all zeros (on a read, the expected value):
  - e1: dir 0, one write of 0.
  - e2: dir 0, read 0 then write 1.
  - e3: dir 0, read 1 then write 0.
  - e4: dir 1, read 0 then write 1.
  - e5: dir 1, read 1 then write 0.
  - e6: dir 1, one read of 0.
- R4: In a two-operation element, addr_adv_o is 0 on the read cycle and 1 on the write cycle. In a one-operation element, addr_adv_o is 1 on every cycle.
- R5: step_done_i is taken only on a cycle with addr_adv_o high; the next element starts in the following cycle. step_done_i on a hold cycle is ignored.
- R6: seed_high_o is 1 exactly in the cycle in which element 3 takes step_done_i, so element 4 starts at the top address.
- R7: done_o rises in the cycle after element 6 takes step_done_i. It stays high, with op_valid_o low, until start_i is sampled high.
- R8: For each address, a complete run issues 5 reads and 5 writes, and a fault-free memory gives no fails. With read data stuck at 1 on an 8192 x 32 memory, the run counts 532480 failing bits.
- R9: An asynchronous reset during a run returns the block to idle at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run when idle or done |
| step_done_i | input | 1 | Datapath terminal pulse: last address reached on an advancing operation |
| op_valid_o | output | 1 | A memory operation is issued this cycle |
| addr_dir_o | output | 1 | 0 ascending, 1 descending |
| addr_adv_o | output | 1 | 1 advance address after this operation, 0 hold |
| wr_en_o | output | 1 | 1 write, 0 read |
| data_pol_o | output | 1 | Write value or expected read value: 1 all ones, 0 all zeros |
| seed_low_o | output | 1 | Load the bottom address |
| seed_high_o | output | 1 | Load the top address |
| done_o | output | 1 | Run complete |

## Verification
The block itself has no size parameter. The bench therefore sizes its own datapath model at run time: a 16-word, 32-bit memory for cycle-exact sequence runs, and an 8192-word memory with read data stuck at 1 to reach the 532480 fail total. The small memory brings every element boundary, wrap-around and reseed within a few hundred cycles. It also makes room for pokes: a terminal pulse on a hold cycle, and a start during a run. The large run checks the operation counts at full scale.

// File: rtl/mts_pkg.sv
package mts_pkg;
  localparam int unsigned NUM_ELEMS   = 6;
  localparam int unsigned ELEM_W      = $clog2(NUM_ELEMS);
  localparam int unsigned LAST_ELEM   = NUM_ELEMS - 1;
  localparam int unsigned RESEED_ELEM = 2;

  typedef logic [ELEM_W-1:0] elem_idx_t;

  typedef struct packed {
    logic down;
    logic do_rd;
    logic do_wr;
    logic rd_pol;
    logic wr_pol;
  } elem_attr_t;

  typedef struct packed {
    logic valid;
    logic dir;
    logic adv;
    logic we;
    logic pol;
  } ctl_word_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} seq_state_e;
endpackage

// File: rtl/mts_elem_table.sv
module mts_elem_table
  import mts_pkg::*;
(
  input  elem_idx_t  idx_i,
  output elem_attr_t attr_o
);
  always_comb begin
    attr_o = '0;
    unique case (idx_i)
      ELEM_W'(0): attr_o = '{down: 1'b0, do_rd: 1'b0, do_wr: 1'b1, rd_pol: 1'b0, wr_pol: 1'b0};
      ELEM_W'(1): attr_o = '{down: 1'b0, do_rd: 1'b1, do_wr: 1'b1, rd_pol: 1'b0, wr_pol: 1'b1};
      ELEM_W'(2): attr_o = '{down: 1'b0, do_rd: 1'b1, do_wr: 1'b1, rd_pol: 1'b1, wr_pol: 1'b0};
      ELEM_W'(3): attr_o = '{down: 1'b1, do_rd: 1'b1, do_wr: 1'b1, rd_pol: 1'b0, wr_pol: 1'b1};
      ELEM_W'(4): attr_o = '{down: 1'b1, do_rd: 1'b1, do_wr: 1'b1, rd_pol: 1'b1, wr_pol: 1'b0};
      ELEM_W'(5): attr_o = '{down: 1'b1, do_rd: 1'b1, do_wr: 1'b0, rd_pol: 1'b0, wr_pol: 1'b0};
      default:    attr_o = '0;
    endcase
  end
endmodule

// File: rtl/mts_op_gen.sv
module mts_op_gen
  import mts_pkg::*;
(
  input  elem_attr_t attr_i,
  input  logic       running_i,
  input  logic       phase_i,
  output logic       two_op_o,
  output ctl_word_t  ctl_o
);
  assign two_op_o = attr_i.do_rd & attr_i.do_wr;

  always_comb begin
    ctl_o = '0;
    if (running_i) begin
      ctl_o.valid = 1'b1;
      ctl_o.dir   = attr_i.down;
      if (two_op_o) begin
        // read holds the address, write moves it
        ctl_o.we  = phase_i;
        ctl_o.adv = phase_i;
        ctl_o.pol = phase_i ? attr_i.wr_pol : attr_i.rd_pol;
      end else begin
        ctl_o.we  = attr_i.do_wr;
        ctl_o.adv = 1'b1;
        ctl_o.pol = attr_i.do_wr ? attr_i.wr_pol : attr_i.rd_pol;
      end
    end
  end
endmodule

// File: rtl/mts_fsm.sv
module mts_fsm
  import mts_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      step_done_i,
  input  logic      two_op_i,
  input  logic      adv_i,
  output logic      running_o,
  output elem_idx_t elem_o,
  output logic      phase_o,
  output logic      seed_low_o,
  output logic      seed_high_o,
  output logic      done_o
);
  seq_state_e state_q;
  elem_idx_t  elem_q;
  logic       phase_q;
  logic       accept;

  assign running_o   = (state_q == ST_RUN);
  assign accept      = running_o & adv_i & step_done_i;
  assign seed_low_o  = start_i & ~running_o;
  assign seed_high_o = accept & (elem_q == ELEM_W'(RESEED_ELEM));
  assign done_o      = (state_q == ST_DONE);
  assign elem_o      = elem_q;
  assign phase_o     = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      elem_q  <= '0;
      phase_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (two_op_i && !phase_q) begin
            phase_q <= 1'b1;
          end else begin
            phase_q <= 1'b0;
            if (accept) begin
              if (elem_q == ELEM_W'(LAST_ELEM)) state_q <= ST_DONE;
              else                              elem_q  <= elem_q + ELEM_W'(1);
            end
          end
        end
        default: begin
          if (start_i) begin
            state_q <= ST_RUN;
            elem_q  <= '0;
            phase_q <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/march_seq.sv
module march_seq
  import mts_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic step_done_i,
  output logic op_valid_o,
  output logic addr_dir_o,
  output logic addr_adv_o,
  output logic wr_en_o,
  output logic data_pol_o,
  output logic seed_low_o,
  output logic seed_high_o,
  output logic done_o
);
  elem_idx_t  elem;
  elem_attr_t attr;
  ctl_word_t  ctl;
  logic       running, phase, two_op;

  mts_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .step_done_i (step_done_i),
    .two_op_i    (two_op),
    .adv_i       (ctl.adv),
    .running_o   (running),
    .elem_o      (elem),
    .phase_o     (phase),
    .seed_low_o  (seed_low_o),
    .seed_high_o (seed_high_o),
    .done_o      (done_o)
  );

  mts_elem_table u_tab (
    .idx_i  (elem),
    .attr_o (attr)
  );

  mts_op_gen u_op (
    .attr_i    (attr),
    .running_i (running),
    .phase_i   (phase),
    .two_op_o  (two_op),
    .ctl_o     (ctl)
  );

  assign op_valid_o = ctl.valid;
  assign addr_dir_o = ctl.dir;
  assign addr_adv_o = ctl.adv;
  assign wr_en_o    = ctl.we;
  assign data_pol_o = ctl.pol;
endmodule

// File: rtl/march_seq_chk.sv
module march_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic op_valid_o,
  input logic addr_dir_o,
  input logic addr_adv_o,
  input logic wr_en_o,
  input logic data_pol_o,
  input logic seed_low_o,
  input logic seed_high_o,
  input logic done_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_o |-> (!wr_en_o && !addr_adv_o && !seed_high_o));

  assert_start_first_op_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_low_o |=> (op_valid_o && !addr_dir_o && wr_en_o && !data_pol_o));

  assert_hold_is_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && !addr_adv_o) |-> !wr_en_o);

  assert_hold_then_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && !addr_adv_o) |=> (op_valid_o && addr_adv_o && wr_en_o));

  assert_hold_keeps_elem_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && !addr_adv_o) |=> $stable(addr_dir_o));

  assert_reseed_to_desc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_high_o |=> (op_valid_o && addr_dir_o && !wr_en_o && !data_pol_o));

  assert_done_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !op_valid_o);

  assert_done_after_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(op_valid_o && addr_dir_o && !wr_en_o && addr_adv_o));
endmodule

bind march_seq march_seq_chk u_chk (.*);

// File: tb/sim_march_seq.sv
module sim_march_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;
  localparam int SMALL_TOP  = 15;
  localparam int BIG_TOP    = 8191;
  localparam int DW         = 32;
  // per element: {down, two_op, op0_we, op0_pol, op1_we, op1_pol}  (R3)
  localparam logic [5:0] ELEM_TAB [6] = '{
    6'b0_0_1_0_0_0, 6'b0_1_0_0_1_1, 6'b0_1_0_1_1_0,
    6'b1_1_0_0_1_1, 6'b1_1_0_1_1_0, 6'b1_0_0_0_0_0};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, force_sd = 1'b0;
  logic op_valid, dir, adv, we, pol, seed_lo, seed_hi, done, step_done;
  int checks = 0, errors = 0;

  int top_addr = SMALL_TOP;
  bit stuck = 1'b0;
  int addr = 0;
  int reads = 0, writes = 0, fails = 0;
  logic [DW-1:0] mem [0:SMALL_TOP];

  always #(CLK_PERIOD/2) clk = ~clk;

  march_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .step_done_i(step_done),
    .op_valid_o(op_valid), .addr_dir_o(dir), .addr_adv_o(adv), .wr_en_o(we),
    .data_pol_o(pol), .seed_low_o(seed_lo), .seed_high_o(seed_hi), .done_o(done));

  // datapath model
  assign step_done = force_sd |
    (op_valid & adv & (dir ? (addr == 0) : (addr == top_addr)));

  always @(posedge clk) begin
    logic [DW-1:0] q;
    q = stuck ? DW'(1) : mem[addr[3:0]];
    if (op_valid) begin
      if (we) begin
        writes <= writes + 1;
        if (!stuck) mem[addr[3:0]] <= {DW{pol}};
      end else begin
        reads <= reads + 1;
        fails <= fails + $countones(q ^ {DW{pol}});
      end
    end
    if (seed_lo) addr <= 0;
    else if (seed_hi) addr <= top_addr;
    else if (op_valid && adv)
      addr <= dir ? ((addr == 0) ? top_addr : addr - 1)
                  : ((addr == top_addr) ? 0 : addr + 1);
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Walk the table cycle by cycle; returns count of mismatching cycles.
  task automatic run_march(input int top, input bit stuck_in, input bit poke, output int bad);
    bad = 0;
    top_addr = top; stuck = stuck_in;
    reads = 0; writes = 0; fails = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int e = 0; e < 6; e++) begin
      for (int a = 0; a <= top; a++) begin
        for (int op = 0; op < (ELEM_TAB[e][4] ? 2 : 1); op++) begin
          logic exp_we, exp_pol, exp_adv;
          int exp_addr;
          exp_we   = op ? ELEM_TAB[e][1] : ELEM_TAB[e][3];
          exp_pol  = op ? ELEM_TAB[e][0] : ELEM_TAB[e][2];
          exp_adv  = ELEM_TAB[e][4] ? (op == 1) : 1'b1;
          exp_addr = ELEM_TAB[e][5] ? top - a : a;
          if (op_valid !== 1'b1 || dir !== ELEM_TAB[e][5] || we !== exp_we ||
              pol !== exp_pol || adv !== exp_adv || addr != exp_addr || done !== 1'b0) begin
            if (bad == 0)
              $display("mismatch e%0d a%0d op%0d: v%b d%b w%b p%b adv%b addr%0d", e + 1, a, op,
                       op_valid, dir, we, pol, adv, addr);
            bad++;
          end
          // R5: terminal pulse on a hold cycle must be ignored
          if (poke && e == 1 && a == 2 && op == 0) force_sd = 1'b1;
          // R2/R7: start during a run must be ignored
          if (poke && e == 3 && a == 1 && op == 0) start = 1'b1;
          @(negedge clk);
          force_sd = 1'b0; start = 1'b0;
        end
      end
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", WD_CYCLES);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    for (int i = 0; i <= SMALL_TOP; i++) mem[i] = '0;
    #(CLK_PERIOD * 2 + 1);
    chk(op_valid === 1'b0 && we === 1'b0 && adv === 1'b0 && done === 1'b0, "R1 reset", op_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(op_valid === 1'b0 && done === 1'b0 && seed_hi === 1'b0, "R1 idle", op_valid, 0);

    start = 1'b1; #1;
    chk(seed_lo === 1'b1, "R2 seed_low on start", seed_lo, 1);
    start = 1'b0;

    // fault-free run with pokes
    run_march(SMALL_TOP, 1'b0, 1'b1, bad);
    chk(bad == 0, "R3 R4 R5 R6 sequence with pokes", bad, 0);
    chk(done === 1'b1 && op_valid === 1'b0, "R7 done after element 6", done, 1);
    chk(reads == 5 * (SMALL_TOP + 1), "R8 reads per address", reads, 5 * (SMALL_TOP + 1));
    chk(writes == 5 * (SMALL_TOP + 1), "R8 writes per address", writes, 5 * (SMALL_TOP + 1));
    chk(fails == 0, "R8 fault-free fails", fails, 0);

    repeat (10) @(negedge clk);
    chk(done === 1'b1 && op_valid === 1'b0, "R7 done holds", done, 1);

    // rerun from done: seed_low brings address back to 0
    run_march(SMALL_TOP, 1'b0, 1'b0, bad);
    chk(bad == 0, "R2 R6 rerun from done", bad, 0);
    chk(fails == 0, "R8 rerun fails", fails, 0);

    // reset during run
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    chk(op_valid === 1'b1, "R9 running before reset", op_valid, 1);
    rst_n = 1'b0; #1;
    chk(op_valid === 1'b0 && done === 1'b0 && we === 1'b0, "R9 async reset idles", op_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(op_valid === 1'b0 && done === 1'b0, "R1 idle after reset", op_valid, 0);

    // full-size run with read data stuck at 1
    run_march(BIG_TOP, 1'b1, 1'b0, bad);
    chk(bad == 0, "R3 full-size sequence", bad, 0);
    chk(fails == 532480, "R8 stuck-at-1 fail total", fails, 532480);
    chk(reads == 5 * (BIG_TOP + 1), "R8 full-size reads", reads, 5 * (BIG_TOP + 1));
    chk(done === 1'b1, "R7 done full-size", done, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule